// File: doc/BRIEF.md
# Slot-Gated Pattern Generator and Checker

This block produces and checks a test bit stream that lives only inside selected timeslots of a T1 line. A separate channel selector supplies, for every line bit, one strobe saying the bit belongs to a generate channel and another saying it belongs to a check channel. The block advances its pattern state only on those bits. Across the gaps the state is held, so the selected bits, joined end to end, carry one unbroken sequence. The pattern is either a pseudorandom LFSR sequence or a fixed programmable word of 1 to 32 bits that repeats.

Two per-direction options change which bits count. The 56 kbit/s option drops the last bit of each selected channel. The whole-line option counts every line bit, framing bits included, and ignores the channel strobes. The checker reseeds its own LFSR from received bits until it has seen a long error-free run, then declares lock. While locked it counts mismatches in a saturating counter. A burst of errors ends lock. A latch-and-clear strobe copies the count to a holding output and clears it.

Top module: `prbs_slot_engine`

## Requirements
- R1: The generator moves to its next bit only in a cycle with `bit_stb`=1 that qualifies: `gen_unf`=1, or `gen_slot`=1 and not (`gen_n56`=1 with `slot_last`=1). In every other cycle `tx_bit` holds its value.
- R2: With `pat_sel`=2'b00 the generated bits b[n] follow b[n]=b[n-15] xor b[n-14] (x^15+x^14+1). After reset the seed is all ones, so the first `tx_bit` is 0.
- R3: With `pat_sel`=2'b01 the generated bits follow b[n]=b[n-20] xor b[n-17] (x^20+x^17+1).
- R4: With `pat_sel`[1]=1, generated bit n after reset is `rep_pat`[n mod (`rep_last`+1)]. `rep_last` holds the pattern length minus one (0 to 31).
- R5: With `gen_n56`=1, a selected bit marked `slot_last` is skipped, so the sequence in the other seven bits stays continuous.
- R6: With `gen_unf`=1, every `bit_stb` bit advances the generator whatever the slot strobe says.
- R7: The checker sets `locked` on the edge that completes 48 consecutive matching checked bits. A looped-back stream that is aligned from reset locks at exactly the 48th bit.
- R8: In a PRBS mode the all-zero stream is never accepted, so an all-zero input never reaches lock.
- R9: Only while `locked`=1 does a mismatching checked bit raise `err_cnt` by one. Mismatches while unlocked are not counted.
- R10: After lock, checked bits are grouped in consecutive 64-bit windows. Five errors in one window keep lock. The sixth error in a window clears `locked` on that bit's edge.
- R11: `err_cnt` saturates at all ones.
- R12: `latch_clr` copies `err_cnt` into `err_latched` and clears `err_cnt` on the same edge. Otherwise `err_latched` holds its value.
- R13: In repeating-word mode, an unlocked checker holds its pattern position on every mismatch. It therefore slides into alignment with an offset stream and then locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_stb | input | 1 | A line bit is present this cycle |
| slot_last | input | 1 | This bit is the eighth bit of its channel |
| gen_slot | input | 1 | This bit belongs to a generate channel |
| det_slot | input | 1 | This bit belongs to a check channel |
| gen_unf | input | 1 | Generator runs on every line bit |
| det_unf | input | 1 | Checker runs on every line bit |
| gen_n56 | input | 1 | Generator skips the eighth bit of each channel |
| det_n56 | input | 1 | Checker skips the eighth bit of each channel |
| pat_sel | input | 2 | 00 = 15-stage LFSR, 01 = 20-stage LFSR, 1x = repeating word |
| rep_pat | input | 32 | Repeating word, bit 0 sent first |
| rep_last | input | 5 | Repeating word length minus one |
| rx_bit | input | 1 | Received bit to check |
| latch_clr | input | 1 | Capture and clear the error count |
| tx_bit | output | 1 | Generated bit for the current qualifying cycle |
| locked | output | 1 | Checker is in lock |
| err_cnt | output | ERR_W | Saturating count of errors while locked |
| err_latched | output | ERR_W | Count captured by the last `latch_clr` |

## Verification
`tx_bit` is combinational from the held generator state. The bench therefore reads it just after driving a bit, before the edge that consumes it, and compares it with the recurrence or the word index for that bit. `locked`, `err_cnt` and `err_latched` change on the edge of the bit that causes the change. The bench samples them one time step after that edge, so the lock check at exactly 48 bits and the drop at exactly the sixth windowed error fall on the bit where the count completes. The latch-and-clear strobe is applied in a cycle with no checked bit, and both outputs are read after that single edge.

// File: rtl/prbs_slot_engine.sv
module prbs_slot_engine #(
  parameter int ERR_W     = 16,
  parameter int LOCK_RUN  = 48,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             slot_last,
  input  logic             gen_slot,
  input  logic             det_slot,
  input  logic             gen_unf,
  input  logic             det_unf,
  input  logic             gen_n56,
  input  logic             det_n56,
  input  logic [1:0]       pat_sel,
  input  logic [31:0]      rep_pat,
  input  logic [4:0]       rep_last,
  input  logic             rx_bit,
  input  logic             latch_clr,
  output logic             tx_bit,
  output logic             locked,
  output logic [ERR_W-1:0] err_cnt,
  output logic [ERR_W-1:0] err_latched
);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int LOSS_W = $clog2(LOSS_ERRS + 1);

  logic [19:0]       g_s, d_s;
  logic [4:0]        g_idx, d_idx;
  logic [RUN_W-1:0]  run;
  logic [WIN_W-1:0]  win_cnt;
  logic [LOSS_W-1:0] win_err;
  logic [LOSS_W:0]   win_sum;
  logic gen_adv, det_adv, is_rep, short_poly;
  logic g_fb, g_zero, d_fb, d_zero, d_exp, miss, bump;

  assign is_rep     = pat_sel[1];
  assign short_poly = ~pat_sel[0];
  assign gen_adv = bit_stb & (gen_unf | (gen_slot & ~(gen_n56 & slot_last)));
  assign det_adv = bit_stb & (det_unf | (det_slot & ~(det_n56 & slot_last)));

  assign g_fb   = short_poly ? g_s[14] ^ g_s[13] : g_s[19] ^ g_s[16];
  assign g_zero = short_poly ? (g_s[14:0] == '0) : (g_s == '0);
  assign d_fb   = short_poly ? d_s[14] ^ d_s[13] : d_s[19] ^ d_s[16];
  assign d_zero = short_poly ? (d_s[14:0] == '0) : (d_s == '0);

  assign tx_bit  = is_rep ? rep_pat[g_idx] : (g_fb | g_zero);
  assign d_exp   = is_rep ? rep_pat[d_idx] : (d_fb | d_zero);
  assign miss    = rx_bit ^ d_exp;
  assign bump    = det_adv & locked & miss;
  assign win_sum = {1'b0, win_err} + (LOSS_W+1)'(miss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_s   <= '1;
      g_idx <= '0;
    end else if (gen_adv) begin
      if (is_rep) g_idx <= (g_idx == rep_last) ? 5'd0 : g_idx + 5'd1;
      else        g_s   <= {g_s[18:0], tx_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_s   <= '1;
      d_idx <= '0;
    end else if (det_adv) begin
      if (is_rep) begin
        if (locked || !miss) d_idx <= (d_idx == rep_last) ? 5'd0 : d_idx + 5'd1;
      end else begin
        d_s <= {d_s[18:0], locked ? d_exp : rx_bit};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      run     <= '0;
      win_cnt <= '0;
      win_err <= '0;
    end else if (det_adv) begin
      if (!locked) begin
        run <= miss ? '0 : run + 1'b1;
        if (!miss && run == RUN_W'(LOCK_RUN - 1)) begin
          locked  <= 1'b1;
          win_cnt <= '0;
          win_err <= '0;
        end
      end else if (win_sum == (LOSS_W+1)'(LOSS_ERRS)) begin
        locked  <= 1'b0;
        run     <= '0;
        win_cnt <= '0;
        win_err <= '0;
      end else if (win_cnt == WIN_W'(WIN_LEN - 1)) begin
        win_cnt <= '0;
        win_err <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        win_err <= win_sum[LOSS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt     <= '0;
      err_latched <= '0;
    end else if (latch_clr) begin
      err_latched <= err_cnt;
      err_cnt     <= ERR_W'(bump);
    end else if (bump && err_cnt != '1) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end
endmodule

module prbs_slot_engine_chk #(
  parameter int ERR_W    = 16,
  parameter int LOCK_RUN = 48,
  parameter int RUN_W    = $clog2(LOCK_RUN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             latch_clr,
  input logic             locked,
  input logic             gen_adv,
  input logic [19:0]      g_s,
  input logic [4:0]       g_idx,
  input logic [RUN_W-1:0] run,
  input logic [ERR_W-1:0] err_cnt,
  input logic [ERR_W-1:0] err_latched
);
  // R1
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_adv |=> ($stable(g_s) && $stable(g_idx)));
  // R7
  lock_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(run) == RUN_W'(LOCK_RUN - 1)));
  // R9
  unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_clr && !locked) |=> $stable(err_cnt));
  // R9
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_clr |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));
  // R11
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_clr && err_cnt == '1) |=> err_cnt == '1);
  // R12
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |=> err_latched == $past(err_cnt));
  // R12
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_clr |=> $stable(err_latched));
endmodule

bind prbs_slot_engine prbs_slot_engine_chk #(.ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN)) chk_i (.*);

// File: tb/prbs_slot_engine_test.sv
`timescale 1ns/1ps
module prbs_slot_engine_test;
  logic clk = 0, rst_n = 0;
  logic bit_stb = 0, slot_last = 0, gen_slot = 0, det_slot = 0;
  logic gen_unf = 0, det_unf = 0, gen_n56 = 0, det_n56 = 0;
  logic [1:0]  pat_sel = 0;
  logic [31:0] rep_pat = 0;
  logic [4:0]  rep_last = 0;
  logic rx_bit = 0, latch_clr = 0;
  logic tx_bit, locked, sat_locked, sat_tx;
  logic [15:0] err_cnt, err_latched;
  logic [3:0]  sat_cnt, sat_latched;
  int vectors = 0, fails = 0;
  logic last_tx;

  always #4 clk = ~clk;

  prbs_slot_engine uut (.*);
  prbs_slot_engine #(.ERR_W(4)) uut_sat (
    .clk, .rst_n, .bit_stb, .slot_last, .gen_slot, .det_slot, .gen_unf, .det_unf,
    .gen_n56, .det_n56, .pat_sel, .rep_pat, .rep_last, .rx_bit, .latch_clr,
    .tx_bit(sat_tx), .locked(sat_locked), .err_cnt(sat_cnt), .err_latched(sat_latched));

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; bit_stb = 0; gen_slot = 0; det_slot = 0; slot_last = 0;
    gen_unf = 0; det_unf = 0; gen_n56 = 0; det_n56 = 0; rx_bit = 0; latch_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // rxm: 0 loopback, 1 all zero, 2 random
  task automatic one_bit(input logic g, input logic d, input logic last, input int rxm, input logic flip);
    @(negedge clk);
    bit_stb = 1; gen_slot = g; det_slot = d; slot_last = last;
    #1 last_tx = tx_bit;
    rx_bit = (rxm == 0) ? (last_tx ^ flip) : (rxm == 1) ? 1'b0 : 1'($urandom);
    @(posedge clk); #1;
    bit_stb = 0;
  endtask

  task automatic gen_run(input int nbits, input logic [1:0] ps, input logic n56, input logic unf);
    logic [31:0] hist = 0;
    int cnt = 0;
    logic hold = 0, prev_t = 0, t, g, last, stb, adv;
    pat_sel = ps;
    do_reset();
    gen_n56 = n56; gen_unf = unf;
    while (cnt < nbits) begin
      g = ($urandom % 3) != 0; last = ($urandom % 4) == 0; stb = ($urandom % 5) != 0;
      @(negedge clk);
      bit_stb = stb; gen_slot = g; slot_last = last; det_slot = 0;
      #1 t = tx_bit;
      if (hold) chk(t == prev_t, (n56 && g && last && stb && !unf) ? "R5" : "R1", t, prev_t);
      adv = stb & (unf | (g & ~(n56 & last)));
      if (adv) begin
        if (ps[1]) chk(t == rep_pat[cnt % (int'(rep_last) + 1)], unf ? "R6" : "R4", t, rep_pat[cnt % (int'(rep_last) + 1)]);
        else if (!ps[0] && cnt >= 15) chk(t == (hist[14] ^ hist[13]), unf ? "R6" : (n56 ? "R5" : "R2"), t, hist[14] ^ hist[13]);
        else if (ps[0] && cnt >= 20) chk(t == (hist[19] ^ hist[16]), unf ? "R6" : (n56 ? "R5" : "R3"), t, hist[19] ^ hist[16]);
        hist = {hist[30:0], t};
        cnt++;
      end
      hold = !adv; prev_t = t;
      @(posedge clk);
    end
    @(negedge clk); bit_stb = 0;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    pat_sel = 2'b00;
    do_reset();
    @(negedge clk); #1;
    chk(tx_bit == 1'b0, "R2", tx_bit, 0);
    chk(locked == 1'b0, "R7", locked, 0);
    chk(err_cnt == 0, "R9", err_cnt, 0);

    gen_run(1500, 2'b00, 0, 0);
    gen_run(1500, 2'b01, 0, 0);
    gen_run(1000, 2'b00, 1, 0);
    gen_run(1000, 2'b01, 0, 1);
    rep_pat = $urandom; rep_last = 5'd31;
    gen_run(300, 2'b10, 0, 0);
    rep_pat = $urandom; rep_last = 5'd0;
    gen_run(100, 2'b11, 0, 0);
    for (int k = 0; k < 3; k++) begin
      rep_pat = $urandom; rep_last = 5'($urandom);
      gen_run(200, 2'b10, k == 1, 0);
    end

    // R7 exact lock timing, then R9/R10/R12
    pat_sel = 2'b00; do_reset();
    for (int i = 0; i < 47; i++) one_bit(1, 1, 0, 0, 0);
    chk(locked == 1'b0, "R7", locked, 0);
    one_bit(1, 1, 0, 0, 0);
    chk(locked == 1'b1, "R7", locked, 1);
    for (int k = 0; k < 200; k++) begin
      logic f;
      f = (k == 10) || (k == 120) || (k >= 130 && k <= 134);
      one_bit(1, 1, 0, 0, f);
      if (k == 10) chk(err_cnt == 1, "R9", err_cnt, 1);
    end
    chk(locked == 1'b1, "R10", locked, 1);
    chk(err_cnt == 7, "R9", err_cnt, 7);
    for (int k = 200; k < 206; k++) begin
      one_bit(1, 1, 0, 0, k >= 200);
      if (k == 204) chk(locked == 1'b1, "R10", locked, 1);
    end
    chk(locked == 1'b0, "R10", locked, 0);
    chk(err_cnt == 13, "R10", err_cnt, 13);
    for (int k = 0; k < 200; k++) one_bit(1, 1, 0, 2, 0);
    chk(err_cnt == 13, "R9", err_cnt, 13);
    @(negedge clk); latch_clr = 1;
    @(posedge clk); #1 latch_clr = 0;
    chk(err_latched == 13, "R12", err_latched, 13);
    chk(err_cnt == 0, "R12", err_cnt, 0);
    for (int k = 0; k < 20; k++) one_bit(0, 0, 0, 2, 0);
    chk(err_latched == 13, "R12", err_latched, 13);

    // R8 all-zero input
    pat_sel = 2'b01; do_reset();
    for (int k = 0; k < 300; k++) one_bit(0, 1, 0, 1, 0);
    chk(locked == 1'b0, "R8", locked, 0);
    pat_sel = 2'b00; do_reset();
    for (int k = 0; k < 300; k++) one_bit(0, 1, 0, 1, 0);
    chk(locked == 1'b0, "R8", locked, 0);

    // R11 saturation on 4-bit instance
    pat_sel = 2'b00; do_reset();
    for (int k = 0; k < 48; k++) one_bit(1, 1, 0, 0, 0);
    for (int k = 0; k < 320; k++) one_bit(1, 1, 0, 0, (k % 16) == 5);
    chk(locked == 1'b1, "R10", locked, 1);
    chk(err_cnt == 20, "R9", err_cnt, 20);
    chk(sat_cnt == 4'hF, "R11", sat_cnt, 15);

    // R5/R6 checker with Nx56 and whole-line loopback
    pat_sel = 2'b01; do_reset();
    gen_n56 = 1; det_n56 = 1;
    for (int k = 0; k < 400; k++) begin
      logic s;
      s = ($urandom % 3) != 0;
      one_bit(s, s, ($urandom % 4) == 0, 0, 0);
    end
    chk(locked == 1'b1, "R5", locked, 1);
    chk(err_cnt == 0, "R5", err_cnt, 0);
    do_reset();
    gen_unf = 1; det_unf = 1;
    for (int k = 0; k < 200; k++) one_bit(1'($urandom), 1'($urandom), 0, 0, 0);
    chk(locked == 1'b1, "R6", locked, 1);
    chk(err_cnt == 0, "R6", err_cnt, 0);

    // R13 repeating word realignment
    pat_sel = 2'b10; rep_pat = 32'h0000_00B5; rep_last = 5'd9;
    do_reset();
    for (int k = 0; k < 3; k++) one_bit(1, 0, 0, 0, 0);
    chk(locked == 1'b0, "R13", locked, 0);
    for (int k = 0; k < 300; k++) one_bit(1, 1, 0, 0, 0);
    chk(locked == 1'b1, "R13", locked, 1);
    chk(err_cnt == 0, "R13", err_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule